// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block decides, for each pin of a general-purpose I/O port, whether the pin is requesting an interrupt. It then merges the per-pin requests into two request lines. Each pin keeps a one-bit copy of the last level it accepted. A pin takes a new level only when the sample strobe is high, the pin is configured as an input, and its input enable is set. On each accepted sample, three per-pin configuration bits pick the trigger rule that compares the old and new levels:
- edge select picks pulse (edge) or hold (level) behaviour;
- any-edge makes every change count, whatever the polarity;
- polarity picks rising or falling in edge mode, and active-high or active-low in level mode.

An edge trigger produces a pending bit that lasts exactly one clock cycle. A level trigger produces a pending bit that holds its value until the next accepted sample of that pin. The pending vector is an output. Two independent enable masks select which pending bits reach request line A and request line B. The masks act combinationally, so a mask change reaches the request lines in the same cycle.

The block sits behind a register interface and an input synchroniser, which supply the configuration, masks and already-synchronised pin levels.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the pending vector, both request lines and every pin's stored level are 0.
- R2: A pin with edge=1 and any-edge=1 sets its pending bit when an accepted sample differs from its stored level, whatever the polarity bit.
- R3: A pin with edge=1 and any-edge=0 sets its pending bit only on a 0-to-1 change when polarity=0, and only on a 1-to-0 change when polarity=1.
- R4: In edge mode a pending bit is high for exactly the one cycle after the accepted sample that caused it, unless that next cycle's accepted sample causes it again.
- R5: A pin with edge=0 sets its pending bit on an accepted sample whose level differs from its polarity bit (polarity=0 active-high, polarity=1 active-low).
- R6: In level mode, an accepted sample at the inactive level clears the pending bit, and the request lines fall in the same cycle.
- R7: irq_a is 1 exactly when some bit is set in both the pending vector and mask_a; irq_b follows the same rule with mask_b.
- R8: A pin with direction=1 (output) or input-enable=0 ignores its level input. Its stored level is not updated, its level-mode pending bit holds its value, and it raises no edge event.
- R9: A change to mask_a or mask_b shows on the request lines in the same cycle, with no clock edge needed.
- R10: With the sample strobe low, level-mode pending bits hold their values and edge-mode pending bits are 0 after the next clock edge.
- R11: Edge detection compares against the last accepted level of that pin, which is 0 after reset. Samples that were ignored are not part of that history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_lvl | input | NPINS | Synchronised pin levels |
| smp_vld | input | 1 | Sample strobe: levels are accepted this cycle |
| cfg_dir | input | NPINS | 1 = pin is an output, ignored here |
| cfg_inen | input | NPINS | 1 = input path enabled |
| cfg_pol | input | NPINS | Polarity: falling / active-low when 1 |
| cfg_edge | input | NPINS | 1 = edge triggered, 0 = level triggered |
| cfg_both | input | NPINS | 1 = any edge (edge mode only) |
| mask_a | input | NPINS | Enable mask for request A |
| mask_b | input | NPINS | Enable mask for request B |
| irq_a | output | 1 | Request line A |
| irq_b | output | 1 | Request line B |
| pend | output | NPINS | Pending vector |

## Verification
An accepted sample shows on the pending vector, and through it on both request lines, after one clock edge. The bench drives each sample at a falling edge and compares 1 ns after the next rising edge, against a model that steps once per clock.

Mask changes have no register on their path. They are applied at a falling edge and compared 1 ns later, with no rising edge in between.

The pseudo-random sweep gives the 16 pins a fixed spread of trigger modes. Each pending bit is tagged with the requirement its mode exercises. This shows the one-cycle edge pulses, the held level bits, and the blocked pins in their exact cycles.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [1:0] {
      TRIG_LEVEL = 2'd0,
      TRIG_RISE  = 2'd1,
      TRIG_FALL  = 2'd2,
      TRIG_ANY   = 2'd3
   } trig_e;

   // Turn the three per-pin configuration bits into one trigger rule.
   function automatic trig_e trig_decode(input logic edge_sel,
                                         input logic any_sel,
                                         input logic pol_sel);
      if (!edge_sel)    return TRIG_LEVEL;
      else if (any_sel) return TRIG_ANY;
      else if (pol_sel) return TRIG_FALL;
      else              return TRIG_RISE;
   endfunction

endpackage

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
   import gpio_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_in,
   input  logic vld,
   input  logic dir,
   input  logic inen,
   input  logic pol,
   input  logic edge_sel,
   input  logic any_sel,
   output logic pend
);

   trig_e kind;
   logic  take;
   logic  lvl_q;
   logic  hit;

   assign take = vld & ~dir & inen;
   assign kind = trig_decode(edge_sel, any_sel, pol);

   always_comb begin
      unique case (kind)
         TRIG_RISE:  hit = ~lvl_q & lvl_in;
         TRIG_FALL:  hit = lvl_q & ~lvl_in;
         TRIG_ANY:   hit = lvl_q ^ lvl_in;
         default:    hit = lvl_in ^ pol;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         pend  <= 1'b0;
      end else if (take) begin
         lvl_q <= lvl_in;
         pend  <= hit;
      end else if (kind != TRIG_LEVEL) begin
         pend  <= 1'b0;
      end
   end

   assert_edge_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && kind != TRIG_LEVEL) |=> !pend);

   assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && kind == TRIG_LEVEL) |=> $stable(pend));

   assert_level_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && kind == TRIG_LEVEL) |=> (pend == ($past(lvl_in) ^ $past(pol))));

   assert_any_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && kind == TRIG_ANY) |=> (pend == ($past(lvl_in) ^ $past(lvl_q))));

   assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!take) |=> $stable(lvl_q));

endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce #(
   parameter int NPINS = 16,
   parameter int NREQ  = 2
) (
   input  logic [NPINS-1:0]            pend,
   input  logic [NREQ-1:0][NPINS-1:0]  mask,
   output logic [NREQ-1:0]             req
);

   if (NREQ < 1) begin : g_bad_nreq
      $error("gpio_irq_reduce: NREQ must be at least 1");
   end

   for (genvar r = 0; r < NREQ; r++) begin : g_req
      assign req[r] = |(pend & mask[r]);
   end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int NPINS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] smp_lvl,
   input  logic             smp_vld,
   input  logic [NPINS-1:0] cfg_dir,
   input  logic [NPINS-1:0] cfg_inen,
   input  logic [NPINS-1:0] cfg_pol,
   input  logic [NPINS-1:0] cfg_edge,
   input  logic [NPINS-1:0] cfg_both,
   input  logic [NPINS-1:0] mask_a,
   input  logic [NPINS-1:0] mask_b,
   output logic             irq_a,
   output logic             irq_b,
   output logic [NPINS-1:0] pend
);

   localparam int NREQ = 2;

   if (NPINS < 1 || NPINS > 64) begin : g_bad_npins
      $error("gpio_irq_detect: NPINS must lie in 1..64");
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      gpio_irq_pin u_pin (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl_in   (smp_lvl[i]),
         .vld      (smp_vld),
         .dir      (cfg_dir[i]),
         .inen     (cfg_inen[i]),
         .pol      (cfg_pol[i]),
         .edge_sel (cfg_edge[i]),
         .any_sel  (cfg_both[i]),
         .pend     (pend[i])
      );
   end

   logic [NREQ-1:0][NPINS-1:0] mask_all;
   logic [NREQ-1:0]            req;

   assign mask_all[0] = mask_a;
   assign mask_all[1] = mask_b;

   gpio_irq_reduce #(.NPINS(NPINS), .NREQ(NREQ)) u_reduce (
      .pend (pend),
      .mask (mask_all),
      .req  (req)
   );

   assign irq_a = req[0];
   assign irq_b = req[1];

   assert_irq_a_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_a |-> ((pend & mask_a) != '0));

   assert_irq_b_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_b |-> ((pend & mask_b) != '0));

   assert_irq_a_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & mask_a) == '0) |-> !irq_a);

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (pend == '0));

endmodule

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
module sim_gpio_irq_detect;

   localparam int N = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] smp_lvl = '0;
   logic         smp_vld = 1'b0;
   logic [N-1:0] cfg_dir = '0, cfg_inen = '0, cfg_pol = '0, cfg_edge = '0, cfg_both = '0;
   logic [N-1:0] mask_a = '0, mask_b = '0;
   logic         irq_a, irq_b;
   logic [N-1:0] pend;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [N-1:0] m_lvl  = '0;
   logic [N-1:0] m_pend = '0;

   always #2.5 clk = ~clk;

   gpio_irq_detect #(.NPINS(N)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_lvl(smp_lvl), .smp_vld(smp_vld),
      .cfg_dir(cfg_dir), .cfg_inen(cfg_inen), .cfg_pol(cfg_pol),
      .cfg_edge(cfg_edge), .cfg_both(cfg_both),
      .mask_a(mask_a), .mask_b(mask_b),
      .irq_a(irq_a), .irq_b(irq_b), .pend(pend));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic string pin_tag(input int i);
      if (cfg_dir[i] || !cfg_inen[i]) return "R8";
      if (cfg_edge[i] && cfg_both[i]) return "R2";
      if (cfg_edge[i])                return "R3";
      return "R5";
   endfunction

   task automatic check_all(input string irq_tag);
      for (int i = 0; i < N; i++)
         chk(pin_tag(i), {31'd0, pend[i]}, {31'd0, m_pend[i]});
      chk(irq_tag, {31'd0, irq_a}, {31'd0, |(m_pend & mask_a)});
      chk(irq_tag, {31'd0, irq_b}, {31'd0, |(m_pend & mask_b)});
   endtask

   // Model one clock: expected results from the requirement rules.
   task automatic step(input logic [N-1:0] lv, input logic v);
      @(negedge clk);
      smp_lvl = lv;
      smp_vld = v;
      for (int i = 0; i < N; i++) begin
         bit acc = v && !cfg_dir[i] && cfg_inen[i];
         bit o = m_lvl[i];
         bit n = lv[i];
         if (acc) begin
            if (!cfg_edge[i])     m_pend[i] = (n != cfg_pol[i]);
            else if (cfg_both[i]) m_pend[i] = (n != o);
            else if (cfg_pol[i])  m_pend[i] = (o == 1 && n == 0);
            else                  m_pend[i] = (o == 0 && n == 1);
            m_lvl[i] = n;
         end else if (cfg_edge[i]) begin
            m_pend[i] = 1'b0;
         end
      end
      @(posedge clk);
      #1;
   endtask

   initial begin : watchdog
      #1000000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] lfsr;
      cfg_inen = '1;
      mask_a = '1;
      mask_b = 16'h00F0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", {16'd0, pend}, 32'd0);
      chk("R1", {31'd0, irq_a}, 32'd0);
      chk("R1", {31'd0, irq_b}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // Rising-edge mode: first sample after reset compares against 0.
      cfg_edge = '1; cfg_both = '0; cfg_pol = '0;
      step(16'hFFFF, 1);
      chk("R11", {16'd0, pend}, 32'h0000FFFF);
      chk("R11", {31'd0, irq_b}, 32'd1);
      step(16'hFFFF, 0);
      chk("R4", {16'd0, pend}, 32'd0);
      chk("R4", {31'd0, irq_a}, 32'd0);
      step(16'hFFFF, 1);
      chk("R3", {16'd0, pend}, 32'd0);

      // Level mode, active low.
      cfg_edge = '0; cfg_pol = '1;
      step(16'h0000, 1);
      chk("R5", {16'd0, pend}, 32'h0000FFFF);
      step(16'hFFFF, 0);
      step(16'h1234, 0);
      chk("R10", {16'd0, pend}, 32'h0000FFFF);
      chk("R10", {31'd0, irq_a}, 32'd1);
      step(16'hFFFF, 1);
      chk("R6", {16'd0, pend}, 32'd0);
      chk("R6", {31'd0, irq_a}, 32'd0);
      chk("R6", {31'd0, irq_b}, 32'd0);

      // Blocked pin keeps old history: pin 0 as output, then re-enabled.
      cfg_edge = 16'h0001; cfg_both = '0; cfg_pol = '0; cfg_dir = 16'h0001;
      step(16'h0000, 1);
      chk("R8", {31'd0, pend[0]}, 32'd0);
      cfg_dir = '0;
      step(16'h0001, 1);
      chk("R11", {31'd0, pend[0]}, 32'd0);
      step(16'h0000, 1);
      step(16'h0001, 1);
      chk("R3", {31'd0, pend[0]}, 32'd1);

      // Sweep: each pin gets a mode from its index bits.
      for (int i = 0; i < N; i++) begin
         cfg_edge[i] = i[0];
         cfg_both[i] = i[1];
         cfg_pol[i]  = i[2];
      end
      mask_a = 16'h5A5A;
      mask_b = 16'h8421;
      lfsr = 16'hACE1;
      for (int k = 0; k < 300; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr, (k % 5) != 0);
         check_all("R7");
      end

      // Sweep with blocked pins: 0..7 outputs, 8..11 disabled.
      cfg_dir  = 16'h00FF;
      cfg_inen = 16'hF0F0;
      for (int k = 0; k < 200; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr ^ 16'h3C3C, (k % 3) != 0);
         check_all("R7");
      end

      // Mask sweep with held level bits, no clock edge between change and check.
      cfg_dir = '0; cfg_inen = '1; cfg_edge = '0; cfg_pol = '0; cfg_both = '0;
      step(16'hA5C3, 1);
      check_all("R7");
      for (int k = 0; k < 48; k++) begin
         @(negedge clk);
         mask_a = 16'(1 << (k % 16));
         mask_b = ~mask_a & 16'(k * 16'h0101);
         #1;
         chk("R9", {31'd0, irq_a}, {31'd0, |(16'hA5C3 & mask_a)});
         chk("R9", {31'd0, irq_b}, {31'd0, |(16'hA5C3 & mask_b)});
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule